// File: doc/BRIEF.md
# Program Counter and Call/Return Sequencer

This block owns the instruction address of a small 4-bit controller core with a 3072-word code space. Every cycle in which the decoder presents an instruction class, it computes the next fetch address: a plain advance by one or two words, a short branch within the current 64-word page, a long branch to any address, a call to one of sixteen fixed grid entries, a call to the lower 2K words, or a return. Branches are conditional on the status flag; calls and returns are not.

Calls and interrupt entries save a 16-bit frame (the four ALU flags and the return address) on a 13-level return stack held in registers. The stack pointer counts downward and may be loaded by software to any level. A pending interrupt, already arbitrated and presented one-hot, is taken only while the interrupt-enable bit is set. Taking it saves the address of the instruction that was not executed and clears the enable bit. Return-from-interrupt hands the saved flags back to the flag register through a one-cycle restore strobe and sets the enable bit again.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, pc is 000h, sp is 12, intEn is 0, stackErr is 0 and restoreValid is 0.
- R2: With instValid high, class 0 (one-word) advances pc by 1 and class 1 (two-word) by 2, and unlisted codes 11 to 15 act like class 0. Addresses wrap from BFFh back to 000h, so pc never reaches C00h. With instValid low, pc holds.
- R3: Class 2 (short branch) with sfIn=1 loads pc with bits 11..6 of (pc+1) and operand bits 5..0. With sfIn=0, pc advances by 1.
- R4: Class 3 (long branch) with sfIn=1 loads pc with operand[11:0]. With sfIn=0, pc advances by 2.
- R5: Class 4 (grid call) pushes pc+1 and jumps to 8n+6, where n=operand[3:0] is in 1..15. n=0 jumps to 086h. The jump does not depend on sfIn.
- R6: Class 5 (far call) pushes pc+2 and jumps to {0, operand[10:0]}, so the target is always below 800h.
- R7: Class 6 (return) loads pc from the most recent frame and moves sp up by one. It leaves intEn and restoreValid unchanged.
- R8: Class 7 (interrupt return) does what class 6 does. In the next cycle it also pulses restoreValid for one cycle, with restoreFlags equal to the flagsIn value saved in the frame, and sets intEn to 1.
- R9: While intEn=1 and vecReq is non-zero, the request takes precedence over the instruction, including when instValid is low. The block pushes the current pc (not advanced) and flagsIn, clears intEn, and jumps to the vector for the request bit: bit0 002h, bit1 006h, bit2 008h, bit3 00Ah, bit4 00Ch.
- R10: While intEn=0, vecReq has no effect, and pc follows the instruction.
- R11: A push writes the frame at level sp and then decrements sp. At sp=0 the first push fills level 0 and sp stays 0. A further push sets the sticky stackErr, writes nothing and jumps as usual. The next return then pops level 0 and sp stays 0.
- R12: Class 8 loads sp from operand[3:0] when that value is 12 or less and empties level 0. Values 13 to 15 leave sp unchanged. A pop at sp=12 with the stack empty sets stackErr, leaves sp at 12 and loads pc with 000h.
- R13: Class 9 sets intEn and class 10 clears it. Both advance pc by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction class is presented this cycle |
| instClass | input | 4 | Decoded instruction class (codes in R2 to R13) |
| operand | input | 12 | Operand bits of the instruction |
| sfIn | input | 1 | Status flag, the branch condition |
| flagsIn | input | 4 | Current four ALU flags, saved with each frame |
| vecReq | input | 5 | One-hot arbitrated interrupt request |
| pc | output | 12 | Program counter (next fetch address) |
| sp | output | 4 | Return-stack pointer |
| intEn | output | 1 | Interrupt-enable bit |
| stackErr | output | 1 | Sticky overflow/underflow indicator |
| restoreValid | output | 1 | One-cycle strobe: write restoreFlags to the flags |
| restoreFlags | output | 4 | Flags popped by an interrupt return |

## Verification
Directed sequences come first. Short branches are tried at a page edge and at the top of the code space, where the incremented address wraps, which separates taken from not-taken and shows the page-keeping behaviour. Every grid entry is called and returned, which separates n=0 from the 8n+6 rule. Each request bit is taken with a distinct flag pattern and then returned from, which tells the vectors apart and shows the flags making the round trip. Overflow and underflow are driven at both ends of the stack, and a long run of mixed random classes, conditions and requests is then compared every cycle against a behavioural model of pc, sp, enable, error and restore outputs.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [3:0] {
    CLS_SEQ1       = 4'd0,
    CLS_SEQ2       = 4'd1,
    CLS_SHORT_BR   = 4'd2,
    CLS_LONG_BR    = 4'd3,
    CLS_GRID_CALL  = 4'd4,
    CLS_FAR_CALL   = 4'd5,
    CLS_RETURN     = 4'd6,
    CLS_INT_RETURN = 4'd7,
    CLS_SP_LOAD    = 4'd8,
    CLS_IE_SET     = 4'd9,
    CLS_IE_CLR     = 4'd10
  } instClass_e;

  typedef enum logic {
    PCSRC_TARGET = 1'b0,
    PCSRC_STACK  = 1'b1
  } pcSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   pcLoad;
    pcSrc_e pcSrc;
    logic   push;
    logic   pop;
    logic   restore;
    logic   ieSet;
    logic   ieClr;
    logic   spLoad;
    logic   intEntry;
  } strobe_t;

endpackage

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH   = 13,
  parameter int ENTRY_W = 16,
  parameter int SP_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic               pop,
  input  logic               spLoad,
  input  logic [SP_W-1:0]    spVal,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [SP_W-1:0]    sp,
  output logic [ENTRY_W-1:0] rdData,
  output logic               err
);

  localparam logic [SP_W-1:0] TOP = SP_W'(DEPTH - 1);

  logic               full;
  logic               atBottom;
  logic               isEmpty;
  logic               overPush;
  logic               underPop;
  logic [SP_W-1:0]    rdIdx;
  logic [ENTRY_W-1:0] levelQ [DEPTH];

  assign atBottom = (sp == '0);
  assign isEmpty  = (sp == TOP) && !full;
  assign overPush = push && full;
  assign underPop = pop && isEmpty;
  assign rdIdx    = full ? '0 : sp + 1'b1;

  // One register per level, written only when it is the push slot
  for (genvar g = 0; g < DEPTH; g++) begin : gLevel
    logic [ENTRY_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (push && !full && (sp == SP_W'(g))) begin
        q <= wrData;
      end
    end
    assign levelQ[g] = q;
  end

  always_comb begin
    if (isEmpty) begin
      rdData = '0;
    end else begin
      rdData = levelQ[rdIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp   <= TOP;
      full <= 1'b0;
    end else if (spLoad) begin
      if (spVal <= TOP) begin
        sp   <= spVal;
        full <= 1'b0;
      end
    end else if (push) begin
      if (!full) begin
        if (atBottom) begin
          full <= 1'b1;
        end else begin
          sp <= sp - 1'b1;
        end
      end
    end else if (pop) begin
      if (full) begin
        full <= 1'b0;
      end else if (!isEmpty) begin
        sp <= sp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      err <= 1'b0;
    end else if (overPush || underPop) begin
      err <= 1'b1;
    end
  end

  AST_SP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) sp <= TOP); // R12
  AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN) full |-> atBottom); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) err |=> err); // R11
  AST_OVERPUSH_HOLD: assert property (@(posedge clk) disable iff (!rstN) (push && full) |=> (full && sp == '0 && err)); // R11
  AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rstN) (push && !full && !atBottom && !spLoad) |=> (sp == $past(sp) - 1'b1)); // R11
  AST_UNDERPOP_HOLD: assert property (@(posedge clk) disable iff (!rstN) (pop && isEmpty && !spLoad) |=> (sp == TOP && err)); // R12

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int CODE_WORDS  = 3072,
  parameter int SP_W        = 4,
  parameter int VEC_N       = 5,
  parameter int SHORT_BR_W  = 6,
  parameter int GRID_SEL_W  = 4,
  parameter int GRID_STEP   = 8,
  parameter int GRID_BASE   = 6,
  parameter int GRID_ZERO   = 'h86
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  instClass_e       instClass,
  input  logic [PC_W-1:0]  operand,
  input  logic             sfIn,
  input  logic [VEC_N-1:0] vecReq,
  input  logic [PC_W-1:0]  pc,
  input  logic             intEn,
  output strobe_t          strb,
  output logic [PC_W-1:0]  pcTarget,
  output logic [PC_W-1:0]  pushPc,
  output logic [SP_W-1:0]  spVal
);

  localparam logic [PC_W:0] SPAN = (PC_W+1)'(CODE_WORDS);

  function automatic logic [PC_W-1:0] wrapAdd(input logic [PC_W-1:0] base, input int step);
    logic [PC_W:0] sum;
    sum = {1'b0, base} + (PC_W+1)'(step);
    if (sum >= SPAN) begin
      sum = sum - SPAN;
    end
    return sum[PC_W-1:0];
  endfunction

  function automatic int vecAddr(input int idx);
    return (idx == 0) ? 2 : 4 + 2 * idx;
  endfunction

  logic [PC_W-1:0]       incOne;
  logic [PC_W-1:0]       incTwo;
  logic [PC_W-1:0]       vecTarget;
  logic [PC_W-1:0]       gridTarget;
  logic [PC_W-1:0]       shortTarget;
  logic [PC_W-1:0]       farTarget;
  logic [GRID_SEL_W-1:0] gridSel;
  logic                  vecHit;
  logic                  takeInt;

  assign incOne      = wrapAdd(pc, 1);
  assign incTwo      = wrapAdd(pc, 2);
  assign gridSel     = operand[GRID_SEL_W-1:0];
  assign shortTarget = {incOne[PC_W-1:SHORT_BR_W], operand[SHORT_BR_W-1:0]};
  assign farTarget   = {1'b0, operand[PC_W-2:0]};
  assign takeInt     = intEn && vecHit;

  always_comb begin
    if (gridSel == '0) begin
      gridTarget = PC_W'(GRID_ZERO);
    end else begin
      gridTarget = PC_W'(GRID_STEP * int'(gridSel) + GRID_BASE);
    end
  end

  // Lowest set request bit selects the vector (input is one-hot anyway)
  always_comb begin
    vecTarget = '0;
    vecHit    = 1'b0;
    for (int i = 0; i < VEC_N; i++) begin
      if (vecReq[i] && !vecHit) begin
        vecTarget = PC_W'(vecAddr(i));
        vecHit    = 1'b1;
      end
    end
  end

  always_comb begin
    strb       = '0;
    strb.pcSrc = PCSRC_TARGET;
    pcTarget   = incOne;
    pushPc     = incOne;
    spVal      = operand[SP_W-1:0];
    if (takeInt) begin
      strb.intEntry = 1'b1;
      strb.push     = 1'b1;
      strb.ieClr    = 1'b1;
      strb.pcLoad   = 1'b1;
      pcTarget      = vecTarget;
      pushPc        = pc;
    end else if (instValid) begin
      strb.pcLoad = 1'b1;
      unique case (instClass)
        CLS_SEQ2:      pcTarget = incTwo;
        CLS_SHORT_BR:  pcTarget = sfIn ? shortTarget : incOne;
        CLS_LONG_BR:   pcTarget = sfIn ? operand : incTwo;
        CLS_GRID_CALL: begin
          strb.push = 1'b1;
          pushPc    = incOne;
          pcTarget  = gridTarget;
        end
        CLS_FAR_CALL: begin
          strb.push = 1'b1;
          pushPc    = incTwo;
          pcTarget  = farTarget;
        end
        CLS_RETURN: begin
          strb.pop   = 1'b1;
          strb.pcSrc = PCSRC_STACK;
        end
        CLS_INT_RETURN: begin
          strb.pop     = 1'b1;
          strb.pcSrc   = PCSRC_STACK;
          strb.restore = 1'b1;
          strb.ieSet   = 1'b1;
        end
        CLS_SP_LOAD: strb.spLoad = 1'b1;
        CLS_IE_SET:  strb.ieSet  = 1'b1;
        CLS_IE_CLR:  strb.ieClr  = 1'b1;
        default:     pcTarget = incOne;
      endcase
    end
  end

  AST_ENTRY_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN) strb.intEntry |-> intEn); // R10
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(vecReq)); // R9
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rstN) !(strb.push && strb.pop)); // R7

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int FLAG_W      = 4,
  parameter int STACK_DEPTH = 13,
  parameter int SP_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PC_W-1:0]   pcTarget,
  input  logic [PC_W-1:0]   pushPc,
  input  logic [SP_W-1:0]   spVal,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              intEn,
  output logic              stackErr,
  output logic              restoreValid,
  output logic [FLAG_W-1:0] restoreFlags
);

  localparam int ENTRY_W = FLAG_W + PC_W;

  logic [ENTRY_W-1:0] popData;

  pcs_stack #(
    .DEPTH  (STACK_DEPTH),
    .ENTRY_W(ENTRY_W),
    .SP_W   (SP_W)
  ) i_stack (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strb.push),
    .pop   (strb.pop),
    .spLoad(strb.spLoad),
    .spVal (spVal),
    .wrData({flagsIn, pushPc}),
    .sp    (sp),
    .rdData(popData),
    .err   (stackErr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strb.pcLoad) begin
      pc <= (strb.pcSrc == PCSRC_STACK) ? popData[PC_W-1:0] : pcTarget;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 1'b0;
    end else if (strb.ieClr) begin
      intEn <= 1'b0;
    end else if (strb.ieSet) begin
      intEn <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restoreValid <= 1'b0;
      restoreFlags <= '0;
    end else begin
      restoreValid <= strb.restore;
      if (strb.restore) begin
        restoreFlags <= popData[ENTRY_W-1:PC_W];
      end
    end
  end

  AST_IE_CLEARED_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN) strb.intEntry |=> !intEn); // R9
  AST_IE_SET_ON_RTI: assert property (@(posedge clk) disable iff (!rstN) strb.restore |=> (intEn && restoreValid)); // R8
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rstN) (restoreValid && !strb.restore) |=> !restoreValid); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strb.pcLoad |=> $stable(pc)); // R2

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int CODE_WORDS  = 3072,
  parameter int STACK_DEPTH = 13,
  parameter int VEC_N       = 5,
  parameter int FLAG_W      = 4,
  parameter int CLS_W       = 4,
  localparam int SP_W       = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [CLS_W-1:0]  instClass,
  input  logic [PC_W-1:0]   operand,
  input  logic              sfIn,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [VEC_N-1:0]  vecReq,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              intEn,
  output logic              stackErr,
  output logic              restoreValid,
  output logic [FLAG_W-1:0] restoreFlags
);

  strobe_t         strb;
  logic [PC_W-1:0] pcTarget;
  logic [PC_W-1:0] pushPc;
  logic [SP_W-1:0] spVal;

  pcs_ctrl #(
    .PC_W      (PC_W),
    .CODE_WORDS(CODE_WORDS),
    .SP_W      (SP_W),
    .VEC_N     (VEC_N)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instClass(instClass_e'(instClass)),
    .operand  (operand),
    .sfIn     (sfIn),
    .vecReq   (vecReq),
    .pc       (pc),
    .intEn    (intEn),
    .strb     (strb),
    .pcTarget (pcTarget),
    .pushPc   (pushPc),
    .spVal    (spVal)
  );

  pcs_datapath #(
    .PC_W       (PC_W),
    .FLAG_W     (FLAG_W),
    .STACK_DEPTH(STACK_DEPTH),
    .SP_W       (SP_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pcTarget    (pcTarget),
    .pushPc      (pushPc),
    .spVal       (spVal),
    .flagsIn     (flagsIn),
    .pc          (pc),
    .sp          (sp),
    .intEn       (intEn),
    .stackErr    (stackErr),
    .restoreValid(restoreValid),
    .restoreFlags(restoreFlags)
  );

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  import pcs_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  instClass = 4'd0;
  logic [11:0] operand = '0;
  logic        sfIn = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [4:0]  vecReq = '0;
  logic [11:0] pc;
  logic [3:0]  sp;
  logic        intEn;
  logic        stackErr;
  logic        restoreValid;
  logic [3:0]  restoreFlags;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .operand(operand), .sfIn(sfIn), .flagsIn(flagsIn), .vecReq(vecReq),
    .pc(pc), .sp(sp), .intEn(intEn), .stackErr(stackErr),
    .restoreValid(restoreValid), .restoreFlags(restoreFlags)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int          mPc, mSp, mIe, mErr, mRv, mRf;
  bit          mFull;
  logic [15:0] mStk [13];

  function automatic int wrapPc(input int x);
    return (x >= 3072) ? x - 3072 : x;
  endfunction

  function automatic int vecOf(input logic [4:0] r);
    for (int i = 0; i < 5; i++) if (r[i]) return (i == 0) ? 2 : 4 + 2 * i;
    return 0;
  endfunction

  task automatic mPush(input int pcv, input logic [3:0] fl, inout string tag);
    if (mFull) begin
      mErr = 1; tag = "R11";
    end else begin
      mStk[mSp] = {fl, 12'(pcv)};
      if (mSp == 0) mFull = 1'b1; else mSp--;
    end
  endtask

  task automatic mPop(output logic [15:0] val, inout string tag);
    if (mFull) begin
      mFull = 1'b0; val = mStk[0];
    end else if (mSp == 12) begin
      mErr = 1; val = '0; tag = "R12";
    end else begin
      mSp++; val = mStk[mSp];
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (pc !== 12'(mPc)) begin
      miscompares++; $display("FAIL %s pc actual %03h expected %03h", tag, pc, mPc);
    end
    if (sp !== 4'(mSp)) begin
      miscompares++; $display("FAIL %s sp actual %0d expected %0d", tag, sp, mSp);
    end
    if (intEn !== 1'(mIe)) begin
      miscompares++; $display("FAIL %s intEn actual %0d expected %0d", tag, intEn, mIe);
    end
    if (stackErr !== 1'(mErr)) begin
      miscompares++; $display("FAIL %s stackErr actual %0d expected %0d", tag, stackErr, mErr);
    end
    if (restoreValid !== 1'(mRv)) begin
      miscompares++; $display("FAIL %s restoreValid actual %0d expected %0d", tag, restoreValid, mRv);
    end
    if (restoreFlags !== 4'(mRf)) begin
      miscompares++; $display("FAIL %s restoreFlags actual %h expected %h", tag, restoreFlags, mRf);
    end
  endtask

  // Drive at the falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input instClass_e c, input int op = 0, input bit sf = 1'b1,
                      input logic [3:0] fl = 4'h0, input logic [4:0] req = 5'h0,
                      input bit v = 1'b1);
    string tag;
    logic [15:0] popped;
    instClass = c; operand = 12'(op); sfIn = sf; flagsIn = fl; vecReq = req; instValid = v;
    mRv = 0;
    if (mIe != 0 && req != 0) begin
      tag = "R9";
      mPush(mPc, fl, tag);
      mPc = vecOf(req); mIe = 0;
    end else if (!v) begin
      tag = "R2";
    end else begin
      tag = (req != 0) ? "R10" : "R2";
      case (c)
        CLS_SEQ2:     mPc = wrapPc(mPc + 2);
        CLS_SHORT_BR: begin
          if (tag == "R2") tag = "R3";
          if (sf) mPc = (wrapPc(mPc + 1) & 'hFC0) | (op & 'h3F); else mPc = wrapPc(mPc + 1);
        end
        CLS_LONG_BR: begin
          if (tag == "R2") tag = "R4";
          mPc = sf ? (op & 'hFFF) : wrapPc(mPc + 2);
        end
        CLS_GRID_CALL: begin
          if (tag == "R2") tag = "R5";
          mPush(wrapPc(mPc + 1), fl, tag);
          mPc = ((op & 15) == 0) ? 'h86 : 8 * (op & 15) + 6;
        end
        CLS_FAR_CALL: begin
          if (tag == "R2") tag = "R6";
          mPush(wrapPc(mPc + 2), fl, tag);
          mPc = op & 'h7FF;
        end
        CLS_RETURN: begin
          if (tag == "R2") tag = "R7";
          mPop(popped, tag);
          mPc = int'(popped[11:0]);
        end
        CLS_INT_RETURN: begin
          if (tag == "R2") tag = "R8";
          mPop(popped, tag);
          mPc = int'(popped[11:0]); mRv = 1; mRf = int'(popped[15:12]); mIe = 1;
        end
        CLS_SP_LOAD: begin
          tag = "R12";
          if ((op & 15) <= 12) begin mSp = op & 15; mFull = 1'b0; end
          mPc = wrapPc(mPc + 1);
        end
        CLS_IE_SET: begin tag = "R13"; mIe = 1; mPc = wrapPc(mPc + 1); end
        CLS_IE_CLR: begin tag = "R13"; mIe = 0; mPc = wrapPc(mPc + 1); end
        default: mPc = wrapPc(mPc + 1);
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    mPc = 0; mSp = 12; mIe = 0; mErr = 0; mRv = 0; mRf = 0; mFull = 1'b0;
    for (int i = 0; i < 13; i++) mStk[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");  // reset state

    // R2: plain advance, hold when not valid, unlisted code
    step(CLS_SEQ1); step(CLS_SEQ1); step(CLS_SEQ2);
    step(CLS_LONG_BR, 'h500, 1'b1, 4'h0, 5'h0, 1'b0);
    step(instClass_e'(4'd13));
    // R2: wrap at the top of the code space
    step(CLS_LONG_BR, 'hBFE); step(CLS_SEQ2);
    step(CLS_LONG_BR, 'hBFF); step(CLS_SEQ1);
    // R3: short branch across the wrap and at a page edge
    step(CLS_LONG_BR, 'hBFF); step(CLS_SHORT_BR, 'h15);
    step(CLS_LONG_BR, 'h0FF); step(CLS_SHORT_BR, 'h2A);
    step(CLS_SHORT_BR, 'h3F, 1'b0);
    // R4: long branch not taken
    step(CLS_LONG_BR, 'h777, 1'b0);
    // R5: every grid entry with return (R7)
    for (int n = 0; n < 16; n++) begin
      step(CLS_GRID_CALL, n + 'h30, 1'b0, 4'(n));
      step(CLS_RETURN);
    end
    // R6: far calls, nested, address bit 11 dropped
    step(CLS_FAR_CALL, 'hFFF); step(CLS_FAR_CALL, 'h123);
    step(CLS_RETURN); step(CLS_RETURN);
    // R10: request ignored while disabled
    step(CLS_SEQ1, 0, 1'b1, 4'h3, 5'b00001);
    // R13 then R9/R8 for each vector
    step(CLS_IE_SET);
    for (int i = 0; i < 5; i++) begin
      step(CLS_SEQ2, 0, 1'b1, 4'hA ^ 4'(i), 5'(1 << i));
      step(CLS_SEQ1, 0, 1'b1, 4'h0, 5'(1 << ((i + 1) % 5)));
      step(CLS_INT_RETURN);
      step(CLS_SEQ1);
    end
    step(CLS_SEQ1, 0, 1'b1, 4'h5, 5'b10000, 1'b0);
    step(CLS_INT_RETURN);
    step(CLS_IE_CLR);
    step(CLS_SEQ1, 0, 1'b1, 4'h0, 5'b00100);
    // R12: load ignored above 12, then R11 overflow at the bottom
    step(CLS_SP_LOAD, 14);
    step(CLS_SP_LOAD, 1);
    step(CLS_GRID_CALL, 3, 1'b1, 4'h1);
    step(CLS_GRID_CALL, 5, 1'b1, 4'h2);
    step(CLS_GRID_CALL, 7, 1'b1, 4'h4);
    step(CLS_RETURN); step(CLS_RETURN);
    // R12: underflow at the top
    step(CLS_SP_LOAD, 12);
    step(CLS_RETURN);
    step(CLS_INT_RETURN);
    // Mixed random traffic
    step(CLS_SP_LOAD, 12);
    for (int k = 0; k < 3000; k++) begin
      instClass_e c;
      int op;
      logic [4:0] rq;
      c  = instClass_e'(4'($urandom_range(0, 10)));
      op = (c == CLS_LONG_BR) ? int'($urandom_range(0, 3071)) : int'($urandom_range(0, 4095));
      rq = ($urandom_range(0, 7) == 0) ? 5'(1 << $urandom_range(0, 4)) : 5'h0;
      step(c, op, 1'($urandom), 4'($urandom), rq, ($urandom_range(0, 9) != 0));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule